// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup

This block performs the tag and data lookup of a level-one data cache. The line index and the position inside the line both come from page-offset bits of the virtual address, and those bits never change in translation. The array read therefore starts as soon as a request is accepted and runs in the same cycle as the address translation. In the following cycle the translation unit supplies the physical page number and a translation-valid flag. The block compares the stored physical tag with that page number and either returns the selected 64-bit word or reports a miss.

The cache is direct mapped: 256 lines of 64 bytes. Each line stores a valid bit and the 26-bit physical page number as its tag.

When a lookup misses and the translation is valid, the block stalls. It raises a line-fill request that carries the 40-bit line-aligned physical address. It holds that request until the refill handshake delivers the whole line in one beat. It then writes the line, its tag and its valid bit, and replays the lookup, which now hits.

When the translation is not valid, the block reports a miss and starts no fill, so the fault can be handled elsewhere. A flush input clears every valid bit in one cycle. It is used on a context switch.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset, `respValid`, `respHit` and `fillReq` are low and `reqReady` is high.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. The line index is `reqPageOff[13:6]` and the word select is `reqPageOff[5:3]`. The response for the request appears in the cycle after acceptance, while the translation inputs are presented.
- R3: A response is a hit (`respValid`=1, `respHit`=1) only when the translation is valid, the indexed line is valid and its stored tag equals `tlbPpn`. On a hit, `respData` is the selected word of the line.
- R4: When `tlbHit` is low in the response cycle, the block reports `respValid`=1 and `respHit`=0. It does not raise `fillReq`, neither in that cycle nor afterwards.
- R5: On a tag miss with a valid translation, `respValid` stays low and `reqReady` drops in the response cycle. From the next cycle on, `fillReq` is high with `fillAddr` = {`tlbPpn`, index, 6'b000000}.
- R6: `fillReq` and `fillAddr` hold steady until a cycle in which `fillValid` is high. That handshake writes the line: word w is taken from `fillData[64*w+63:64*w]`. `fillReq` is low in the following cycle.
- R7: Two cycles after the refill handshake, the replayed lookup responds with `respValid`=1, `respHit`=1 and the requested word of the new line. `tlbHit` is ignored during the replay.
- R8: A cycle with `flush` high invalidates every line. Later lookups of previously filled lines miss.
- R9: Two pages that share an index evict each other. After a fill from page B, a lookup of page A at that index misses, and lines at other indices are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| flush | input | 1 | Invalidate all lines |
| reqValid | input | 1 | Lookup request |
| reqPageOff | input | 11 | Page-offset bits 13..3 of the virtual address (index and word select) |
| reqReady | output | 1 | Request can be accepted this cycle |
| tlbHit | input | 1 | Translation valid, presented in the cycle after acceptance |
| tlbPpn | input | 26 | Translated physical page number, same cycle as `tlbHit` |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respData | output | 64 | Selected data word |
| fillReq | output | 1 | Line-fill request |
| fillAddr | output | 40 | Line-aligned physical address of the fill |
| fillValid | input | 1 | Refill line present; completes the fill handshake |
| fillData | input | 512 | Refill line, word 0 in the low bits |

## Verification
The assertions assume that `fillValid` is raised only while `fillReq` is high, and that `flush` is not raised during a fill or replay. They also assume that `tlbHit` and `tlbPpn` belong to the request accepted on the previous edge.

The stimulus respects all of this. It issues one request at a time, and only while `reqReady` is high. It presents the translation exactly one cycle after acceptance and then clears `tlbHit`. It drives `fillValid` for a single cycle after a variable wait, and flushes only when the block is idle.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
  typedef struct packed {
    logic rdEn;       // read tag, valid and word into the compare stage
    logic rdReplay;   // read address comes from the latched miss
    logic missLatch;  // capture page number and index of a missing lookup
    logic fillWr;     // write refill line, tag and valid
    logic useLatch;   // compare against the latched page number
    logic clearAll;   // invalidate every line
  } cacheStrobes_t;
endpackage

// File: rtl/vipt_cache_dpath.sv
module vipt_cache_dpath
  import vipt_cache_pkg::*;
#(
  parameter int PPN_W  = 26,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 6,
  parameter int WORD_W = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cacheStrobes_t                     strb,
  input  logic [IDX_W+OFF_W-1:$clog2(WORD_W/8)] reqPageOff,
  input  logic [PPN_W-1:0]                  tlbPpn,
  input  logic [(8<<OFF_W)-1:0]             fillData,
  output logic                              tagEq,
  output logic [WORD_W-1:0]                 respData,
  output logic [PPN_W+IDX_W+OFF_W-1:0]      fillAddr
);
  localparam int LINES  = 1 << IDX_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WORDS  = (8 << OFF_W) / WORD_W;
  localparam int WSEL_W = OFF_W - BYTE_W;

  logic [LINES-1:0]  validVec;
  logic [PPN_W-1:0]  tagArr  [LINES];
  logic [WORD_W-1:0] dataArr [LINES][WORDS];

  logic [IDX_W-1:0]  s1Idx, missIdx, idxSel;
  logic [WSEL_W-1:0] s1Word, missWord, wordSel;
  logic [PPN_W-1:0]  rdTag, missPpn, cmpPpn;
  logic              rdValid;

  always_comb begin
    idxSel  = strb.rdReplay ? missIdx  : reqPageOff[IDX_W+OFF_W-1:OFF_W];
    wordSel = strb.rdReplay ? missWord : reqPageOff[OFF_W-1:BYTE_W];
    cmpPpn  = strb.useLatch ? missPpn  : tlbPpn;
    tagEq   = rdValid && (rdTag == cmpPpn);
    fillAddr = {missPpn, missIdx, {OFF_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      rdValid  <= 1'b0;
      s1Idx    <= '0;
      s1Word   <= '0;
      missIdx  <= '0;
      missWord <= '0;
      missPpn  <= '0;
    end else begin
      if (strb.clearAll) validVec <= '0;
      else if (strb.fillWr) validVec[missIdx] <= 1'b1;
      if (strb.rdEn) begin
        rdValid <= validVec[idxSel];
        s1Idx   <= idxSel;
        s1Word  <= wordSel;
      end
      if (strb.missLatch) begin
        missPpn  <= tlbPpn;
        missIdx  <= s1Idx;
        missWord <= s1Word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillWr) begin
      tagArr[missIdx] <= missPpn;
      for (int w = 0; w < WORDS; w++)
        dataArr[missIdx][w] <= fillData[w*WORD_W +: WORD_W];
    end
    if (strb.rdEn) begin
      rdTag    <= tagArr[idxSel];
      respData <= dataArr[idxSel][wordSel];
    end
  end
endmodule

// File: rtl/vipt_cache_ctrl.sv
module vipt_cache_ctrl
  import vipt_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          reqValid,
  input  logic          tlbHit,
  input  logic          fillValid,
  input  logic          tagEq,
  output cacheStrobes_t strb,
  output logic          reqReady,
  output logic          respValid,
  output logic          respHit,
  output logic          fillReq
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_REPLAY} ctrlState_t;
  ctrlState_t state, stateNext;
  logic s1Valid, s1Replay, missStart;

  always_comb begin
    missStart = s1Valid && !s1Replay && tlbHit && !tagEq;
    reqReady  = (state == ST_IDLE) && !missStart;
    strb           = '0;
    strb.clearAll  = flush;
    strb.useLatch  = s1Replay;
    strb.missLatch = missStart;
    strb.rdReplay  = (state == ST_REPLAY);
    strb.rdEn      = (reqValid && reqReady) || (state == ST_REPLAY);
    strb.fillWr    = (state == ST_FILL) && fillValid;
    fillReq   = (state == ST_FILL);
    respValid = s1Valid && !missStart;
    respHit   = s1Valid && (s1Replay || tlbHit) && tagEq;
    stateNext = state;
    case (state)
      ST_IDLE:   if (missStart) stateNext = ST_FILL;
      ST_FILL:   if (fillValid) stateNext = ST_REPLAY;
      ST_REPLAY: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      s1Valid  <= 1'b0;
      s1Replay <= 1'b0;
    end else begin
      state    <= stateNext;
      s1Valid  <= strb.rdEn;
      s1Replay <= strb.rdReplay;
    end
  end
endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup
  import vipt_cache_pkg::*;
#(
  parameter int PPN_W  = 26,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 6,
  parameter int WORD_W = 64
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  flush,
  input  logic                                  reqValid,
  input  logic [IDX_W+OFF_W-1:$clog2(WORD_W/8)] reqPageOff,
  output logic                                  reqReady,
  input  logic                                  tlbHit,
  input  logic [PPN_W-1:0]                      tlbPpn,
  output logic                                  respValid,
  output logic                                  respHit,
  output logic [WORD_W-1:0]                     respData,
  output logic                                  fillReq,
  output logic [PPN_W+IDX_W+OFF_W-1:0]          fillAddr,
  input  logic                                  fillValid,
  input  logic [(8<<OFF_W)-1:0]                 fillData
);
  cacheStrobes_t strb;
  logic tagEq;

  vipt_cache_ctrl u_ctrl (
    .clk, .rstN, .flush, .reqValid, .tlbHit, .fillValid, .tagEq,
    .strb, .reqReady, .respValid, .respHit, .fillReq
  );

  vipt_cache_dpath #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_dpath (
    .clk, .rstN, .strb, .reqPageOff, .tlbPpn, .fillData,
    .tagEq, .respData, .fillAddr
  );
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int OFF_W = 6,
  parameter int PA_W  = 40
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic            reqValid,
  input logic            reqReady,
  input logic            tlbHit,
  input logic            respValid,
  input logic            respHit,
  input logic            fillReq,
  input logic [PA_W-1:0] fillAddr,
  input logic            fillValid
);
  a_r3_hit_is_resp: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  a_r4_no_hit_without_xlate: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqReady) && !tlbHit) |-> !respHit);

  a_r5_fill_stalls: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !reqReady);

  a_r5_fill_aligned: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> (fillAddr[OFF_W-1:0] == '0));

  a_r6_fill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> (fillReq && $stable(fillAddr)));

  a_r6_fill_done: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillValid) |=> !fillReq);

  a_r7_replay_hits: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillReq && fillValid, 2) && !$past(flush) && !$past(flush, 2))
      |-> (respValid && respHit));
endmodule

bind vipt_cache_lookup vipt_cache_chk #(.OFF_W(OFF_W), .PA_W(PPN_W+IDX_W+OFF_W)) u_chk (
  .clk, .rstN, .flush, .reqValid, .reqReady, .tlbHit,
  .respValid, .respHit, .fillReq, .fillAddr, .fillValid
);

// File: tb/vipt_cache_lookup_bench.sv
module vipt_cache_lookup_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flush = 1'b0;
  logic         reqValid = 1'b0;
  logic [10:0]  reqPageOff = '0;
  logic         reqReady;
  logic         tlbHit = 1'b0;
  logic [25:0]  tlbPpn = '0;
  logic         respValid, respHit;
  logic [63:0]  respData;
  logic         fillReq;
  logic [39:0]  fillAddr;
  logic         fillValid = 1'b0;
  logic [511:0] fillData = '0;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit          mValid [256];
  logic [25:0] mTag   [256];

  localparam logic [25:0] PAGE_A = 26'h2A5_5C3;
  localparam logic [25:0] PAGE_B = 26'h11C_0F7;

  always #10 clk = ~clk;  // 50 MHz

  vipt_cache_lookup u_vipt_cache_lookup (
    .clk, .rstN, .flush, .reqValid, .reqPageOff, .reqReady, .tlbHit, .tlbPpn,
    .respValid, .respHit, .respData, .fillReq, .fillAddr, .fillValid, .fillData
  );

  function automatic logic [63:0] wordOf(logic [25:0] ppn, logic [7:0] idx, logic [2:0] w);
    return {ppn, idx, w, 1'b1, ppn};
  endfunction

  function automatic logic [511:0] lineOf(logic [25:0] ppn, logic [7:0] idx);
    logic [511:0] l;
    for (int w = 0; w < 8; w++) l[w*64 +: 64] = wordOf(ppn, idx, 3'(w));
    return l;
  endfunction

  task automatic check(bit ok, string req, string ctx, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  task automatic doLookup(logic [7:0] idx, logic [2:0] w, logic [25:0] ppn, bit ok, string ctx);
    bit expHit;
    int waitN;
    check(reqReady == 1'b1, "R2", {ctx, " ready"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1;
    reqPageOff = {idx, w};
    @(negedge clk);
    reqValid = 1'b0;
    tlbHit = ok;
    tlbPpn = ppn;
    #1;
    expHit = ok && mValid[idx] && (mTag[idx] == ppn);
    if (!ok) begin
      check(respValid && !respHit && !fillReq, "R4", {ctx, " xlate miss"},
            64'({respValid, respHit, fillReq}), 64'b100);
      @(negedge clk); #1;
      check(!fillReq && !respValid, "R4", {ctx, " no fill after"}, 64'({fillReq, respValid}), 64'b00);
    end else if (expHit) begin
      check(respValid && respHit, "R3", {ctx, " hit flag"}, 64'({respValid, respHit}), 64'b11);
      check(respData == wordOf(ppn, idx, w), "R3", {ctx, " hit data"}, respData, wordOf(ppn, idx, w));
    end else begin
      check(!respValid && !reqReady, "R5", {ctx, " miss stall"}, 64'({respValid, reqReady}), 64'b00);
      @(negedge clk);
      tlbHit = 1'b0;
      tlbPpn = ~ppn;
      #1;
      check(fillReq && fillAddr == {ppn, idx, 6'b0}, "R5", {ctx, " fill addr"},
            64'(fillAddr), 64'({ppn, idx, 6'b0}));
      waitN = idx % 3;
      for (int k = 0; k < waitN; k++) begin
        @(negedge clk); #1;
        check(fillReq && fillAddr == {ppn, idx, 6'b0} && !reqReady, "R6", {ctx, " fill hold"},
              64'(fillAddr), 64'({ppn, idx, 6'b0}));
      end
      fillValid = 1'b1;
      fillData = lineOf(ppn, idx);
      @(negedge clk);
      fillValid = 1'b0;
      fillData = '0;
      #1;
      mValid[idx] = 1'b1;
      mTag[idx] = ppn;
      check(!fillReq && !respValid, "R6", {ctx, " fill done"}, 64'({fillReq, respValid}), 64'b00);
      @(negedge clk); #1;
      check(respValid && respHit, "R7", {ctx, " replay hit"}, 64'({respValid, respHit}), 64'b11);
      check(respData == wordOf(ppn, idx, w), "R7", {ctx, " replay data"}, respData, wordOf(ppn, idx, w));
    end
    @(negedge clk);
    tlbHit = 1'b0;
    tlbPpn = '0;
    #1;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mValid[i] = 1'b0; mTag[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: state right after reset
    check(!respValid && !respHit && !fillReq && reqReady, "R1", "reset",
          64'({respValid, respHit, fillReq, reqReady}), 64'b0001);
    @(negedge clk); #1;
    // R2: index and word selection over every line, each a cold miss
    for (int i = 0; i < 256; i++) doLookup(8'(i), 3'(i % 8), PAGE_A, 1'b1, "R2 sweep");
    // R3: every line hits with a different word
    for (int i = 0; i < 256; i++) doLookup(8'(i), 3'((i + 3) % 8), PAGE_A, 1'b1, "R3 hit");
    // R4: translation miss on lines that would hit
    for (int i = 0; i < 32; i++) doLookup(8'(i * 7), 3'(i % 8), (i % 2 == 0) ? PAGE_A : PAGE_B, 1'b0, "R4 sweep");
    // R9: page B takes even lines, odd lines keep page A
    for (int i = 0; i < 256; i += 2) doLookup(8'(i), 3'(i % 8), PAGE_B, 1'b1, "R9 evict fill");
    for (int i = 0; i < 256; i++) doLookup(8'(i), 3'((i + 5) % 8), PAGE_A, 1'b1, "R9 evict check");
    // R8: flush then lookups of filled lines miss
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 256; i++) mValid[i] = 1'b0;
    #1;
    for (int i = 0; i < 16; i++) begin
      doLookup(8'(i * 16 + 1), 3'(i % 8), PAGE_A, 1'b1, "R8 flushed");
    end
    check(mValid[1], "R8", "model refilled", 64'(mValid[1]), 64'd1);
    done = 1'b1;
    finishRun();
  end
endmodule